// File: doc/BRIEF.md
# Per-Wave Ordered Load Return Queue

This block is a shared tracking queue for memory loads issued by several hardware threads (waves). A load is issued with the ID of its wave and a small payload. The block returns the number of the queue entry it was given, and that number is the tag the memory system uses for the completion. Completions can arrive in any order. The queue hands finished loads to the register-writeback port, at most one per cycle. Within a wave, loads come out in issue order. A wave whose data is ready is never held back by a slower load from another wave.

Each wave has an outstanding-load counter. A wait with threshold N raises that wave's stall output while its count is above N. Because a wave's loads retire in order, a wave that has waited down to N knows that all but its newest N loads have finished. A mode input restricts retirement to the globally oldest live entry. The bench uses it to show the older cross-wave blocking behaviour next to the default one.

Each queue entry is a three-state machine: `ENT_FREE`, `ENT_WAIT` and `ENT_DONE`. The transitions are *allocate* (`ENT_FREE` to `ENT_WAIT` on an accepted issue), *fill* (`ENT_WAIT` to `ENT_DONE` on a completion carrying its tag) and *retire* (`ENT_DONE` to `ENT_FREE` when the writeback port presents it). Every other input combination keeps the current state. An age matrix records, for each pair of live entries, which one was allocated first. From this, each entry knows whether it is the oldest live entry of its wave and whether it is the oldest live entry overall.

Top module: `wave_return_queue`

## Requirements
- R1: After reset, all entries are free, `iss_ready` is high, `wb_valid` and `cmp_err` are low, every counter reads zero and no stall is raised.
- R2: An issue is accepted on a cycle with `iss_valid` and `iss_ready` both high. `iss_tag` shows the lowest-numbered free entry, and that entry is the one allocated. With all 16 entries occupied, `iss_ready` is low and a request changes no counter.
- R3: A completion moves the tagged entry from waiting to done. A completion whose tag names a free entry changes nothing, and `cmp_err` is high for exactly the cycle after it.
- R4: `wb_valid` is shown during the cycle in which an entry is eligible, and that entry retires at the next clock edge. At most one entry retires per edge, and it is never presented twice. `wb_wave`, `wb_tag` and `wb_payload` carry the wave, entry number and payload given at issue.
- R5: Loads of one wave retire strictly in issue order. A done entry with an older live entry of the same wave is not presented.
- R6: With `in_order_mode` low, a done entry that is the oldest live entry of its wave is eligible even when older entries of other waves are still waiting.
- R7: When several waves have an eligible entry, the grant goes to the first such wave after the wave served last, counting upward and wrapping around.
- R8: A wave's counter rises by one on each accepted issue for that wave and falls by one on each retirement for that wave. An accepted issue and a retirement for the same wave in the same cycle leave it unchanged.
- R9: `stall[w]` is high exactly when `wait_req[w]` is high and the wave's count is greater than its threshold. A threshold at or above the count gives no stall.
- R10: With `in_order_mode` high, only the globally oldest live entry may retire. A done entry waits behind any older live entry of any wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_order_mode | input | 1 | 1: retire only the globally oldest entry |
| iss_valid | input | 1 | Load issue request |
| iss_wave | input | 2 | Wave issuing the load |
| iss_payload | input | 8 | Payload kept with the entry |
| iss_ready | output | 1 | A free entry exists |
| iss_tag | output | 4 | Entry that an issue in this cycle receives |
| cmp_valid | input | 1 | Memory completion |
| cmp_tag | input | 4 | Entry the completion belongs to |
| cmp_err | output | 1 | Previous cycle's completion named a free entry |
| wb_valid | output | 1 | An entry is retiring at the next edge |
| wb_wave | output | 2 | Wave of the retiring entry |
| wb_tag | output | 4 | Entry number of the retiring entry |
| wb_payload | output | 8 | Payload of the retiring entry |
| wait_req | input | 4 | Per-wave wait active |
| wait_thr | input | 20 | Per-wave wait threshold, 5 bits per wave, wave 0 in the low bits |
| stall | output | 4 | Per-wave stall |
| out_cnt | output | 20 | Per-wave outstanding-load counts, 5 bits per wave, wave 0 in the low bits |

## Verification
The bench builds the block with its defaults: four waves, sixteen entries, five-bit counters and an eight-bit payload. With these values, sixteen issues spread over the four waves fill the queue, so refusal when full is reached quickly, and completing the entries in reverse order then exercises ordering within each wave. Four waves also leave room to have two waves ready at once with a third idle. This shows the round-robin grant skipping past the wave served last. The same short issue sequence is run with the mode input low and then high, so that overtaking across waves and global in-order blocking can be compared directly.

// File: rtl/wrq_pkg.sv
`timescale 1ns/1ps
package wrq_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_t;
endpackage

// File: rtl/wrq_entry.sv
`timescale 1ns/1ps
// One queue slot: lifecycle state plus the wave and payload captured on allocate.
module wrq_entry
    import wrq_pkg::*;
#(
    parameter int WID_W     = 2,
    parameter int PAYLOAD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic                 complete,
    input  logic                 retire,
    input  logic [WID_W-1:0]     alloc_wave,
    input  logic [PAYLOAD_W-1:0] alloc_payload,
    output ent_state_t           state,
    output logic [WID_W-1:0]     wave,
    output logic [PAYLOAD_W-1:0] payload
);
    ent_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc)    state_d = ENT_WAIT;
            ENT_WAIT: if (complete) state_d = ENT_DONE;
            ENT_DONE: if (retire)   state_d = ENT_FREE;
            default:                state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave    <= '0;
            payload <= '0;
        end else if (alloc && state_q == ENT_FREE) begin
            wave    <= alloc_wave;
            payload <= alloc_payload;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/wrq_age_matrix.sv
`timescale 1ns/1ps
// Pairwise age record: older_q[i][j] set means entry i was allocated before j.
module wrq_age_matrix #(
    parameter int DEPTH = 16,
    parameter int WID_W = 2,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc,
    input  logic [TAG_W-1:0]       alloc_idx,
    input  logic [DEPTH-1:0]       live,
    input  logic [DEPTH*WID_W-1:0] wave_flat,
    output logic [DEPTH-1:0]       wave_head,
    output logic [DEPTH-1:0]       global_head
);
    logic [DEPTH-1:0] older_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
        end else if (alloc) begin
            for (int j = 0; j < DEPTH; j++) begin
                older_q[j][alloc_idx] <= live[j];
                older_q[alloc_idx][j] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wave_head[i]   = 1'b1;
            global_head[i] = 1'b1;
            for (int j = 0; j < DEPTH; j++) begin
                if (live[j] && older_q[j][i]) begin
                    global_head[i] = 1'b0;
                    if (wave_flat[j*WID_W +: WID_W] == wave_flat[i*WID_W +: WID_W])
                        wave_head[i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/wrq_rr_pick.sv
`timescale 1ns/1ps
// Round-robin choice among requesting waves, starting after the last winner.
module wrq_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             gnt_any,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = last_q;
        for (int k = 1; k <= N; k++) begin
            int s;
            s = (int'(last_q) + k) % N;
            if (!gnt_any && req[s]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= IDX_W'(N - 1);
        else if (gnt_any) last_q <= gnt_idx;
    end
endmodule

// File: rtl/wrq_wave_ctr.sv
`timescale 1ns/1ps
// Per-wave outstanding-load counters and wait-threshold stall.
module wrq_wave_ctr #(
    parameter int NUM_WAVES = 4,
    parameter int CNT_W     = 5,
    parameter int WID_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc_en,
    input  logic [WID_W-1:0]           inc_wave,
    input  logic                       dec_en,
    input  logic [WID_W-1:0]           dec_wave,
    input  logic [NUM_WAVES-1:0]       wait_req,
    input  logic [NUM_WAVES*CNT_W-1:0] wait_thr,
    output logic [NUM_WAVES*CNT_W-1:0] cnt_flat,
    output logic [NUM_WAVES-1:0]       stall
);
    for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
        logic             inc, dec;
        logic [CNT_W-1:0] cnt_q;

        assign inc = inc_en && (inc_wave == WID_W'(w));
        assign dec = dec_en && (dec_wave == WID_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                case ({inc, dec})
                    2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                    2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        assign cnt_flat[w*CNT_W +: CNT_W] = cnt_q;
        assign stall[w] = wait_req[w] && (cnt_q > wait_thr[w*CNT_W +: CNT_W]);
    end
endmodule

// File: rtl/wave_return_queue.sv
`timescale 1ns/1ps
module wave_return_queue
    import wrq_pkg::*;
#(
    parameter int NUM_WAVES = 4,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5,
    parameter int PAYLOAD_W = 8,
    localparam int WID_W = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_order_mode,
    input  logic                       iss_valid,
    input  logic [WID_W-1:0]           iss_wave,
    input  logic [PAYLOAD_W-1:0]       iss_payload,
    output logic                       iss_ready,
    output logic [TAG_W-1:0]           iss_tag,
    input  logic                       cmp_valid,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic                       cmp_err,
    output logic                       wb_valid,
    output logic [WID_W-1:0]           wb_wave,
    output logic [TAG_W-1:0]           wb_tag,
    output logic [PAYLOAD_W-1:0]       wb_payload,
    input  logic [NUM_WAVES-1:0]       wait_req,
    input  logic [NUM_WAVES*CNT_W-1:0] wait_thr,
    output logic [NUM_WAVES-1:0]       stall,
    output logic [NUM_WAVES*CNT_W-1:0] out_cnt
);
    ent_state_t             ent_state [DEPTH];
    logic [PAYLOAD_W-1:0]   ent_payload [DEPTH];
    logic [DEPTH*WID_W-1:0] ent_wave_flat;
    logic [DEPTH-1:0]       live, done, eligible;
    logic [DEPTH-1:0]       alloc_vec, cmp_vec, retire_vec;
    logic [DEPTH-1:0]       wave_head, global_head;
    logic [TAG_W-1:0]       free_idx;
    logic                   any_free, iss_fire;
    logic [NUM_WAVES-1:0]   wave_req;
    logic [TAG_W-1:0]       wave_sel [NUM_WAVES];
    logic                   grant_any;
    logic [WID_W-1:0]       grant_wave;
    logic                   cmp_err_q;

    // Lowest-numbered free entry receives the next issue.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_state[i] == ENT_FREE) begin
                any_free = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end

    assign iss_ready = any_free;
    assign iss_tag   = free_idx;
    assign iss_fire  = iss_valid && any_free;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign alloc_vec[i]  = iss_fire && (free_idx == TAG_W'(i));
        assign cmp_vec[i]    = cmp_valid && (cmp_tag == TAG_W'(i));
        assign retire_vec[i] = wb_valid && (wb_tag == TAG_W'(i));
        assign live[i]       = (ent_state[i] != ENT_FREE);
        assign done[i]       = (ent_state[i] == ENT_DONE);
        assign eligible[i]   = done[i] && (in_order_mode ? global_head[i] : wave_head[i]);

        wrq_entry #(
            .WID_W     (WID_W),
            .PAYLOAD_W (PAYLOAD_W)
        ) u_entry (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc         (alloc_vec[i]),
            .complete      (cmp_vec[i]),
            .retire        (retire_vec[i]),
            .alloc_wave    (iss_wave),
            .alloc_payload (iss_payload),
            .state         (ent_state[i]),
            .wave          (ent_wave_flat[i*WID_W +: WID_W]),
            .payload       (ent_payload[i])
        );
    end

    wrq_age_matrix #(
        .DEPTH (DEPTH),
        .WID_W (WID_W)
    ) u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (iss_fire),
        .alloc_idx   (free_idx),
        .live        (live),
        .wave_flat   (ent_wave_flat),
        .wave_head   (wave_head),
        .global_head (global_head)
    );

    // Each wave offers at most one candidate: its eligible head entry.
    always_comb begin
        for (int w = 0; w < NUM_WAVES; w++) begin
            wave_req[w] = 1'b0;
            wave_sel[w] = '0;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (eligible[i] && (ent_wave_flat[i*WID_W +: WID_W] == WID_W'(w))) begin
                    wave_req[w] = 1'b1;
                    wave_sel[w] = TAG_W'(i);
                end
            end
        end
    end

    wrq_rr_pick #(
        .N     (NUM_WAVES),
        .IDX_W (WID_W)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wave_req),
        .gnt_any (grant_any),
        .gnt_idx (grant_wave)
    );

    assign wb_valid   = grant_any;
    assign wb_wave    = grant_wave;
    assign wb_tag     = wave_sel[grant_wave];
    assign wb_payload = ent_payload[wb_tag];

    always_ff @(posedge clk) begin
        if (!rst_n) cmp_err_q <= 1'b0;
        else        cmp_err_q <= cmp_valid && (ent_state[cmp_tag] == ENT_FREE);
    end
    assign cmp_err = cmp_err_q;

    wrq_wave_ctr #(
        .NUM_WAVES (NUM_WAVES),
        .CNT_W     (CNT_W),
        .WID_W     (WID_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (iss_fire),
        .inc_wave (iss_wave),
        .dec_en   (wb_valid),
        .dec_wave (wb_wave),
        .wait_req (wait_req),
        .wait_thr (wait_thr),
        .cnt_flat (out_cnt),
        .stall    (stall)
    );
endmodule

// File: rtl/wave_return_queue_chk.sv
`timescale 1ns/1ps
module wave_return_queue_chk #(
    parameter int NUM_WAVES = 4,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5,
    parameter int WID_W     = 2,
    parameter int TAG_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       iss_valid,
    input logic                       iss_ready,
    input logic [WID_W-1:0]           iss_wave,
    input logic                       cmp_valid,
    input logic                       cmp_err,
    input logic                       wb_valid,
    input logic [WID_W-1:0]           wb_wave,
    input logic [TAG_W-1:0]           wb_tag,
    input logic [NUM_WAVES-1:0]       stall,
    input logic [NUM_WAVES*CNT_W-1:0] out_cnt
);
    function automatic logic [CNT_W-1:0] cnt_of(input logic [NUM_WAVES*CNT_W-1:0] f,
                                                input logic [WID_W-1:0] w);
        return f[w*CNT_W +: CNT_W];
    endfunction

    logic same_wave_fire;
    assign same_wave_fire = wb_valid && iss_valid && iss_ready && (iss_wave == wb_wave);

    AST_CNT_DROP_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !same_wave_fire) |=> cnt_of(out_cnt, $past(wb_wave)) == $past(cnt_of(out_cnt, wb_wave)) - CNT_W'(1)); // R8
    AST_CNT_HOLD_ON_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        same_wave_fire |=> cnt_of(out_cnt, $past(wb_wave)) == $past(cnt_of(out_cnt, wb_wave))); // R8
    AST_WB_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> cnt_of(out_cnt, wb_wave) != '0); // R8
    AST_WB_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !(wb_valid && wb_tag == $past(wb_tag))); // R4
    AST_ERR_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> $past(cmp_valid)); // R3

    for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wchk
        AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            (out_cnt[w*CNT_W +: CNT_W] == '0) |-> !stall[w]); // R9
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            int'(out_cnt[w*CNT_W +: CNT_W]) <= DEPTH); // R2
    end
endmodule

bind wave_return_queue wave_return_queue_chk #(
    .NUM_WAVES (NUM_WAVES),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W),
    .WID_W     (WID_W),
    .TAG_W     (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_wave  (iss_wave),
    .cmp_valid (cmp_valid),
    .cmp_err   (cmp_err),
    .wb_valid  (wb_valid),
    .wb_wave   (wb_wave),
    .wb_tag    (wb_tag),
    .stall     (stall),
    .out_cnt   (out_cnt)
);

// File: tb/wave_return_queue_bench.sv
`timescale 1ns/1ps
module wave_return_queue_bench;
    localparam int NW = 4;
    localparam int DEPTH = 16;
    localparam int CW = 5;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_order_mode = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_wave = '0;
    logic [PW-1:0] iss_payload = '0;
    logic          iss_ready;
    logic [3:0]    iss_tag;
    logic          cmp_valid = 1'b0;
    logic [3:0]    cmp_tag = '0;
    logic          cmp_err;
    logic          wb_valid;
    logic [1:0]    wb_wave;
    logic [3:0]    wb_tag;
    logic [PW-1:0] wb_payload;
    logic [NW-1:0] wait_req = '0;
    logic [NW*CW-1:0] wait_thr = '0;
    logic [NW-1:0] stall;
    logic [NW*CW-1:0] out_cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wave_return_queue #(
        .NUM_WAVES (NW), .DEPTH (DEPTH), .CNT_W (CW), .PAYLOAD_W (PW)
    ) u_wave_return_queue (
        .clk (clk), .rst_n (rst_n), .in_order_mode (in_order_mode),
        .iss_valid (iss_valid), .iss_wave (iss_wave), .iss_payload (iss_payload),
        .iss_ready (iss_ready), .iss_tag (iss_tag),
        .cmp_valid (cmp_valid), .cmp_tag (cmp_tag), .cmp_err (cmp_err),
        .wb_valid (wb_valid), .wb_wave (wb_wave), .wb_tag (wb_tag), .wb_payload (wb_payload),
        .wait_req (wait_req), .wait_thr (wait_thr), .stall (stall), .out_cnt (out_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cnt_w(input int w);
        return int'(out_cnt[w*CW +: CW]);
    endfunction

    task automatic do_issue(input int w, input int p, output int tag);
        iss_valid = 1'b1;
        iss_wave = 2'(w);
        iss_payload = PW'(p);
        #1 tag = int'(iss_tag);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic do_cmp(input int tag);
        cmp_valid = 1'b1;
        cmp_tag = 4'(tag);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic expect_wb(input string req, input int w, input int tag, input int p);
        chk({req, " wb_valid"}, int'(wb_valid), 1);
        chk({req, " wb_wave"}, int'(wb_wave), w);
        chk({req, " wb_tag"}, int'(wb_tag), tag);
        chk({req, " wb_payload"}, int'(wb_payload), p);
    endtask

    task automatic test_reset();
        chk("R1 iss_ready", int'(iss_ready), 1);
        chk("R1 wb_valid", int'(wb_valid), 0);
        chk("R1 cmp_err", int'(cmp_err), 0);
        for (int w = 0; w < NW; w++) chk("R1 count", cnt_w(w), 0);
        wait_req = '1;
        #1 chk("R9 no stall at zero", int'(stall), 0);
        wait_req = '0;
    endtask

    task automatic test_cross_wave();
        int t0, t1;
        do_issue(0, 8'h11, t0);
        do_issue(1, 8'h22, t1);
        chk("R2 first tag", t0, 0);
        chk("R2 second tag", t1, 1);
        chk("R8 count w0", cnt_w(0), 1);
        chk("R8 count w1", cnt_w(1), 1);
        do_cmp(t1);
        expect_wb("R6 overtake", 1, t1, 8'h22);
        @(negedge clk);
        chk("R6 w0 still pending", int'(wb_valid), 0);
        chk("R8 count w1 after retire", cnt_w(1), 0);
        do_cmp(t0);
        expect_wb("R4 late entry", 0, t0, 8'h11);
        @(negedge clk);
        chk("R8 count w0 after retire", cnt_w(0), 0);
    endtask

    task automatic test_same_wave();
        int a, b;
        do_issue(2, 1, a);
        do_issue(2, 2, b);
        do_cmp(b);
        chk("R5 younger held", int'(wb_valid), 0);
        do_cmp(a);
        expect_wb("R5 older first", 2, a, 1);
        @(negedge clk);
        expect_wb("R5 younger next", 2, b, 2);
        @(negedge clk);
        chk("R5 drained", int'(wb_valid), 0);
    endtask

    task automatic test_wait();
        int t;
        for (int i = 0; i < 3; i++) do_issue(3, 40 + i, t);
        chk("R8 count three", cnt_w(3), 3);
        wait_req = 4'b1100;
        wait_thr = '0;
        wait_thr[3*CW +: CW] = 5'd2;
        #1 chk("R9 stall above threshold", int'(stall[3]), 1);
        chk("R9 idle wave no stall", int'(stall[2]), 0);
        wait_thr[3*CW +: CW] = 5'd3;
        #1 chk("R9 threshold equal", int'(stall[3]), 0);
        wait_thr[3*CW +: CW] = 5'd7;
        #1 chk("R9 threshold above", int'(stall[3]), 0);
        wait_thr[3*CW +: CW] = 5'd2;
        @(negedge clk);
        for (int i = 0; i < 3; i++) do_cmp(i);
        @(negedge clk);
        chk("R8 drained count", cnt_w(3), 0);
        chk("R9 released", int'(stall[3]), 0);
        wait_req = '0;
    endtask

    task automatic test_bad_cmp();
        do_cmp(5);
        chk("R3 error flag", int'(cmp_err), 1);
        chk("R3 no writeback", int'(wb_valid), 0);
        @(negedge clk);
        chk("R3 error one cycle", int'(cmp_err), 0);
        chk("R3 entry untouched", int'(wb_valid), 0);
    endtask

    task automatic test_round_robin();
        int a, b, c, d;
        do_issue(0, 8'hA1, a);
        do_issue(0, 8'hA2, b);
        do_issue(1, 8'hB1, c);
        do_issue(1, 8'hB2, d);
        do_cmp(b);
        do_cmp(d);
        chk("R5 non-heads held", int'(wb_valid), 0);
        do_cmp(c);
        expect_wb("R7 only w1", 1, c, 8'hB1);
        do_cmp(a);
        expect_wb("R7 rotate to w0", 0, a, 8'hA1);
        @(negedge clk);
        expect_wb("R7 rotate to w1", 1, d, 8'hB2);
        @(negedge clk);
        expect_wb("R7 last w0", 0, b, 8'hA2);
        @(negedge clk);
        chk("R7 drained", int'(wb_valid), 0);
    endtask

    task automatic test_same_cycle();
        int t, u;
        do_issue(0, 9, t);
        do_cmp(t);
        chk("R8 count before", cnt_w(0), 1);
        chk("R4 ready head shown", int'(wb_valid), 1);
        do_issue(0, 10, u);
        chk("R8 issue and retire together", cnt_w(0), 1);
        chk("R2 retiring entry not reused", u, t + 1);
        do_cmp(u);
        @(negedge clk);
        chk("R8 drained", cnt_w(0), 0);
    endtask

    task automatic test_full();
        int t;
        int last[NW];
        int got = 0;
        int bad = 0;
        for (int w = 0; w < NW; w++) last[w] = -1;
        for (int i = 0; i < DEPTH; i++) begin
            do_issue(i % NW, i, t);
            chk("R2 sequential tag", t, i);
        end
        chk("R2 full refuses", int'(iss_ready), 0);
        iss_valid = 1'b1;
        iss_wave = 2'd0;
        @(negedge clk);
        iss_valid = 1'b0;
        chk("R2 refused issue no count", cnt_w(0), 4);
        for (int k = 0; k < 40; k++) begin
            if (wb_valid) begin
                if (int'(wb_payload) <= last[wb_wave] || int'(wb_payload) % NW != int'(wb_wave)) bad++;
                last[wb_wave] = int'(wb_payload);
                got++;
            end
            if (k < DEPTH) begin
                cmp_valid = 1'b1;
                cmp_tag = 4'(DEPTH - 1 - k);
            end else begin
                cmp_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R4 all retired", got, DEPTH);
        chk("R5 per-wave order", bad, 0);
        chk("R2 ready again", int'(iss_ready), 1);
        for (int w = 0; w < NW; w++) chk("R8 final count", cnt_w(w), 0);
    endtask

    task automatic test_in_order();
        int t0, t1;
        in_order_mode = 1'b1;
        do_issue(0, 8'h31, t0);
        do_issue(1, 8'h32, t1);
        do_cmp(t1);
        chk("R10 blocked behind other wave", int'(wb_valid), 0);
        do_cmp(t0);
        expect_wb("R10 oldest first", 0, t0, 8'h31);
        @(negedge clk);
        expect_wb("R10 then next", 1, t1, 8'h32);
        @(negedge clk);
        chk("R10 drained", int'(wb_valid), 0);
        in_order_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_cross_wave();
        test_same_wave();
        test_wait();
        test_bad_cmp();
        test_round_robin();
        test_same_cycle();
        test_full();
        test_in_order();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule